// File: doc/BRIEF.md
# Radio Power and Master Clock Mode Controller

This block decides which low-power mode a radio sits in and what appears on its master clock pin. It watches an active-low power pin, a crystal-enable pin, a synchronous power-on reset and one configuration bit that asks for a slow clock while asleep. From these it keeps one of four modes: OFF, IDLE, SLEEP and DEEP SLEEP. OFF is the only mode that wipes the configuration. It raises a one-cycle clear pulse for the register file when the mode falls into OFF. The other modes keep their settings.

The master clock pin carries the 16 MHz reference in every mode except DEEP SLEEP. In DEEP SLEEP it carries a 32 kHz square wave divided from the reference. The change between the two sources is made only at a falling reference edge while the slow clock is low, so no short pulse reaches the pin. An analog power-down vector is also produced. It is all ones in OFF and follows the stored power-down settings in every other mode.

Top module: `radio_pm_ctrl`

## Requirements
- R1: While `rst` is high or `pwr_n` is low at a rising edge, `mode` reads OFF (code 0) after that edge. Mode codes: OFF=0, IDLE=1, SLEEP=2, DEEP SLEEP=3.
- R2: From OFF, with `pwr_n` high and `xtal_en` high at a rising edge, `mode` becomes IDLE (1) after that edge.
- R3: From OFF, with `pwr_n` high and `xtal_en` low, `mode` stays OFF.
- R4: From IDLE, with `xtal_en` low, `mode` becomes SLEEP (2) if `slow_sel` is 0, or DEEP SLEEP (3) if `slow_sel` is 1.
- R5: In SLEEP or DEEP SLEEP with `xtal_en` low, `mode` follows `slow_sel` (0 gives SLEEP, 1 gives DEEP SLEEP). Raising `xtal_en` returns `mode` to IDLE.
- R6: `cfg_clear` is high for exactly one cycle: the first cycle in which `mode` reads OFF after a mode other than OFF. It is low during and straight after reset, and low at all other times.
- R7: `analog_pd` is all ones in OFF and equals `pd_cfg` in IDLE, SLEEP and DEEP SLEEP.
- R8: While the slow source is not selected, `mclk_out` equals the reference clock.
- R9: The slow source toggles after every 250 reference cycles counted from reset release, giving 16 MHz / 500 at a 50% duty cycle. It is selected only in DEEP SLEEP.
- R10: The source select changes only at a falling reference edge while the slow clock is low. `mclk_out` is therefore low just after every falling reference edge unless the slow clock is selected and high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz reference clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| pwr_n | input | 1 | Power pin, active low; low forces OFF |
| xtal_en | input | 1 | Crystal enable pin; low requests sleep |
| slow_sel | input | 1 | Configuration bit: slow clock in sleep |
| pd_cfg | input | 8 | Stored analog power-down settings |
| mode | output | 2 | Current mode code |
| cfg_clear | output | 1 | One-cycle configuration clear pulse |
| analog_pd | output | 8 | Analog power-down enables |
| mclk_out | output | 1 | Master clock output |

## Verification
The properties assume that the pins are synchronous to the reference and stable around each rising edge. They also assume that `slow_sel` and `pd_cfg` are register outputs in the same clock domain. The stimulus changes every input only just after a falling edge. It holds each mode long enough to see several full slow periods. Source switches are requested both while the slow clock is high and while it is low, so the wait for a low level is exercised. Reset and the power pin are pulled from IDLE and from DEEP SLEEP to cover both exits into OFF.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PM_OFF   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2,
        PM_DEEP  = 2'd3
    } pm_mode_e;

    localparam int unsigned REF_HZ_DEF  = 16_000_000;
    localparam int unsigned SLOW_HZ_DEF = 32_000;

    function automatic pm_mode_e sleep_pick(input logic slow_bit);
        return slow_bit ? PM_DEEP : PM_SLEEP;
    endfunction

    function automatic logic is_asleep(input pm_mode_e m);
        return (m == PM_SLEEP) || (m == PM_DEEP);
    endfunction

endpackage

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_n,
    input  logic     xtal_en,
    input  logic     slow_sel,
    output pm_mode_e mode_q,
    output logic     clr_pulse
);
    pm_mode_e nxt;
    pm_mode_e prev_q;

    always_comb begin
        nxt = mode_q;
        unique case (mode_q)
            PM_OFF:  nxt = xtal_en ? PM_IDLE : PM_OFF;
            PM_IDLE: nxt = xtal_en ? PM_IDLE : sleep_pick(slow_sel);
            default: nxt = xtal_en ? PM_IDLE : sleep_pick(slow_sel);
        endcase
        if (!pwr_n) nxt = PM_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_OFF;
            prev_q <= PM_OFF;
        end else begin
            mode_q <= nxt;
            prev_q <= mode_q;
        end
    end

    assign clr_pulse = (mode_q == PM_OFF) && (prev_q != PM_OFF);

endmodule

// File: rtl/pm_slow_div.sv
module pm_slow_div #(
    parameter int unsigned HALF = 250
) (
    input  logic clk,
    input  logic rst,
    output logic slow_q
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            slow_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            slow_q <= ~slow_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pm_clk_mux.sv
module pm_clk_mux (
    input  logic clk,
    input  logic rst,
    input  logic want_slow,
    input  logic slow_clk,
    output logic sel_slow_q,
    output logic mclk
);
    // Select flop moves on the falling reference edge, and only while the
    // slow clock is low, so both sources are low at the moment of change.
    always_ff @(negedge clk) begin
        if (rst) begin
            sel_slow_q <= 1'b0;
        end else if (!slow_clk) begin
            sel_slow_q <= want_slow;
        end
    end

    assign mclk = sel_slow_q ? slow_clk : clk;

endmodule

// File: rtl/radio_pm_ctrl.sv
module radio_pm_ctrl
    import pm_pkg::*;
#(
    parameter int unsigned REF_HZ  = REF_HZ_DEF,
    parameter int unsigned SLOW_HZ = SLOW_HZ_DEF,
    parameter int unsigned PD_W    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_n,
    input  logic            xtal_en,
    input  logic            slow_sel,
    input  logic [PD_W-1:0] pd_cfg,
    output logic [1:0]      mode,
    output logic            cfg_clear,
    output logic [PD_W-1:0] analog_pd,
    output logic            mclk_out
);
    localparam int unsigned DIV_HALF = REF_HZ / (2 * SLOW_HZ);

    pm_mode_e mode_q;
    logic     slow_clk;
    logic     sel_slow;

    pm_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pwr_n     (pwr_n),
        .xtal_en   (xtal_en),
        .slow_sel  (slow_sel),
        .mode_q    (mode_q),
        .clr_pulse (cfg_clear)
    );

    pm_slow_div #(.HALF(DIV_HALF)) u_div (
        .clk    (clk),
        .rst    (rst),
        .slow_q (slow_clk)
    );

    pm_clk_mux u_mux (
        .clk        (clk),
        .rst        (rst),
        .want_slow  (mode_q == PM_DEEP),
        .slow_clk   (slow_clk),
        .sel_slow_q (sel_slow),
        .mclk       (mclk_out)
    );

    assign mode      = mode_q;
    assign analog_pd = (mode_q == PM_OFF) ? {PD_W{1'b1}} : pd_cfg;

endmodule

// File: rtl/radio_pm_ctrl_chk.sv
module radio_pm_ctrl_chk #(
    parameter int unsigned PD_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            pwr_n,
    input logic            xtal_en,
    input logic            slow_sel,
    input logic [PD_W-1:0] pd_cfg,
    input logic [1:0]      mode,
    input logic            cfg_clear,
    input logic [PD_W-1:0] analog_pd
);
    AST_PWR_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
        !pwr_n |=> mode == 2'd0); // R1

    AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && pwr_n && xtal_en) |=> mode == 2'd1); // R2

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && !xtal_en) |=> mode == 2'd0); // R3

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && pwr_n && !xtal_en) |=> mode == {1'b1, $past(slow_sel)}); // R4

    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && pwr_n && xtal_en) |=> mode == 2'd1); // R5

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cfg_clear |=> !cfg_clear); // R6

    AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        cfg_clear |-> (mode == 2'd0 && $past(mode) != 2'd0)); // R6

    AST_PD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0) |-> analog_pd == pd_cfg); // R7

    AST_PD_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> (&analog_pd)); // R7

endmodule

bind radio_pm_ctrl radio_pm_ctrl_chk #(.PD_W(PD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_n     (pwr_n),
    .xtal_en   (xtal_en),
    .slow_sel  (slow_sel),
    .pd_cfg    (pd_cfg),
    .mode      (mode),
    .cfg_clear (cfg_clear),
    .analog_pd (analog_pd)
);

// File: tb/sim_radio_pm_ctrl.sv
module sim_radio_pm_ctrl;
    localparam int PD_W = 8;
    localparam int HALF = 250;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            pwr_n = 1'b0;
    logic            xtal_en = 1'b0;
    logic            slow_sel = 1'b0;
    logic [PD_W-1:0] pd_cfg = 8'h5A;
    logic [1:0]      mode;
    logic            cfg_clear;
    logic [PD_W-1:0] analog_pd;
    logic            mclk_out;

    always #2 clk = ~clk;

    radio_pm_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .pwr_n     (pwr_n),
        .xtal_en   (xtal_en),
        .slow_sel  (slow_sel),
        .pd_cfg    (pd_cfg),
        .mode      (mode),
        .cfg_clear (cfg_clear),
        .analog_pd (analog_pd),
        .mclk_out  (mclk_out)
    );

    int total = 0;
    int bad   = 0;
    bit timeout = 0;
    string mode_req = "R1";

    // behavioural reference
    int m_mode = 0;
    int m_prev = 0;
    int m_cnt  = 0;
    bit m_slow = 0;
    bit m_sel  = 0;
    int slow_edges = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_pos();
        bit old_slow;
        old_slow = m_slow;
        if (rst) begin
            m_mode = 0; m_prev = 0; m_cnt = 0; m_slow = 0;
        end else begin
            int nxt;
            if (!pwr_n)          nxt = 0;
            else if (m_mode == 0) nxt = xtal_en ? 1 : 0;
            else if (xtal_en)    nxt = 1;
            else                 nxt = slow_sel ? 3 : 2;
            m_prev = m_mode;
            m_mode = nxt;
            if (m_cnt == HALF - 1) begin m_cnt = 0; m_slow = !m_slow; end
            else m_cnt++;
        end
        if (old_slow != m_slow) slow_edges++;
    endtask

    task automatic model_neg();
        if (rst) m_sel = 0;
        else if (!m_slow) m_sel = (m_mode == 3);
    endtask

    task automatic step();
        bit exp_clr;
        logic [PD_W-1:0] exp_pd;
        @(posedge clk); #1;
        model_pos();
        chk(mode == m_mode[1:0], mode_req, "mode", mode, m_mode);
        exp_clr = (m_mode == 0) && (m_prev != 0);
        chk(cfg_clear == exp_clr, "R6", "cfg_clear", cfg_clear, exp_clr);
        exp_pd = (m_mode == 0) ? '1 : pd_cfg;
        chk(analog_pd == exp_pd, "R7", "analog_pd", analog_pd, exp_pd);
        chk(mclk_out == (m_sel ? m_slow : 1'b1), m_sel ? "R9" : "R8",
            "mclk_out high phase", mclk_out, m_sel ? m_slow : 1);
        @(negedge clk); #1;
        model_neg();
        chk(mclk_out == (m_sel ? m_slow : 1'b0), "R10", "mclk_out low phase",
            mclk_out, m_sel ? m_slow : 0);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic run_all();
        // reset state: R1
        mode_req = "R1";
        steps(3);
        rst = 1'b0;
        steps(2);
        // R3: power up, crystal still low
        pwr_n = 1'b1; mode_req = "R3";
        steps(5);
        // R2: wake to IDLE
        xtal_en = 1'b1; mode_req = "R2";
        steps(4);
        pd_cfg = 8'hC3; steps(2);
        // R4: IDLE to SLEEP, fast clock kept (R8)
        xtal_en = 1'b0; slow_sel = 1'b0; mode_req = "R4";
        steps(20);
        // R5: SLEEP to DEEP SLEEP, slow clock (R9)
        slow_sel = 1'b1; mode_req = "R5";
        steps(1300);
        // R5: back to SLEEP, switch waits for slow low (R10)
        slow_sel = 1'b0;
        steps(600);
        slow_sel = 1'b1;
        steps(700);
        // R5: wake from DEEP SLEEP to IDLE
        xtal_en = 1'b1;
        steps(300);
        // R4: IDLE straight to DEEP SLEEP
        xtal_en = 1'b0; mode_req = "R4";
        pd_cfg = 8'h0F;
        steps(400);
        // R1 + R6: power pin low from DEEP SLEEP
        pwr_n = 1'b0; mode_req = "R1";
        steps(300);
        // R2 again, then reset from IDLE (R1, no clear pulse per R6)
        pwr_n = 1'b1; xtal_en = 1'b1; mode_req = "R2";
        pd_cfg = 8'hA5;
        steps(6);
        rst = 1'b1; mode_req = "R1";
        steps(3);
        rst = 1'b0;
        steps(3);
        // R1: power low from IDLE with crystal high
        pwr_n = 1'b0;
        steps(4);
        chk(slow_edges >= 4, "R9", "slow clock edges seen", slow_edges, 4);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) chk(1'b0, "R1", "watchdog expired", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule